// File: doc/BRIEF.md
# Arithmetic Logic Unit

This block is the combinational function unit of a register datapath. Two operands and a three-bit operation select come in, together with a carry input. Within the same clock cycle the unit returns a result word and four status flags: carry, signed overflow, zero and negative. Whatever register captures the result sits outside the block.

The arithmetic side uses a single ripple adder. Its second operand is not picked by a multiplexer. Instead, each bit of the second operand is formed by a small gate expression that the two low select bits control. That expression can yield zero, the B operand, the complement of B, or all ones. Combined with the carry input, this one adder covers transfer, increment, addition, subtraction and decrement. The logic side produces four bitwise functions. A final selector, driven by the top select bit, chooses which of the two sides reaches the output.

Top module: `alu_core`

## Requirements
- R1: When sel[2] = 0, res equals (opa + Y + cin) modulo 2^W, where Y is the conditioned second operand defined in R2.
- R2: Bit i of Y is (opb[i] AND sel[0]) OR (NOT opb[i] AND sel[1]). For sel[1:0]: 00 gives all zeros, 01 gives opb, 10 gives NOT opb, and 11 gives all ones.
- R3: sel = 3'b010 with cin = 1 yields opa - opb. sel = 3'b011 with cin = 0 yields opa - 1.
- R4: In arithmetic mode, cout is bit W of the (W+1)-bit sum opa + Y + cin.
- R5: In arithmetic mode, ovf is 1 exactly when opa and Y have the same sign bit and res has the other sign bit.
- R6: When sel[2] = 1, res is a bitwise function chosen by sel[1:0]: 00 gives AND, 01 gives OR, 10 gives XOR, and 11 gives NOT opa.
- R7: When sel[2] = 1, cin has no effect on any output.
- R8: When sel[2] = 1, cout and ovf are both 0.
- R9: zero is 1 exactly when res is all zeros.
- R10: neg equals res[W-1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand (the adder's X input) |
| opb | input | W | Second operand, conditioned before it reaches the adder |
| sel | input | 3 | Operation select. Bit 2 chooses logic (1) or arithmetic (0); bits 1:0 choose the function |
| cin | input | 1 | Adder carry input, not used in logic mode |
| res | output | W | Result word |
| cout | output | 1 | Adder carry out, 0 in logic mode |
| ovf | output | 1 | Signed overflow, 0 in logic mode |
| zero | output | 1 | Result is all zeros |
| neg | output | 1 | Most significant bit of the result |

## Verification
The checker's immediate assertions evaluate only when every input and output holds a known value. They also assume the inputs stay constant long enough for the ripple chain to settle, so they are meaningful only for inputs that change at discrete times. The bench satisfies this by changing operands and select once per cycle, shortly after the rising edge, and by sampling at the falling edge. It drives every one of the eight select codes with both carry values across a fixed set of corner operands: zero, all ones, the sign bit alone, the largest positive value, one, and an alternating pattern. It then adds pseudo-random pairs, plus direct subtraction and decrement cases whose expected values are taken from plain subtraction.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Conditioning applied to the second adder operand, indexed by sel[1:0]
    typedef enum logic [1:0] {
        BY_ZERO = 2'b00,
        BY_PASS = 2'b01,
        BY_INV  = 2'b10,
        BY_ONES = 2'b11
    } bcond_e;

    // Bitwise function in logic mode, indexed by sel[1:0]
    typedef enum logic [1:0] {
        LF_AND = 2'b00,
        LF_OR  = 2'b01,
        LF_XOR = 2'b10,
        LF_INV = 2'b11
    } logic_fn_e;

    typedef struct packed {
        logic       use_logic;
        logic [1:0] fn;
    } alu_sel_t;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
    } alu_flags_t;

    function automatic alu_sel_t decode_sel(input logic [2:0] s);
        alu_sel_t d;
        d.use_logic = s[2];
        d.fn        = s[1:0];
        return d;
    endfunction

endpackage

// File: rtl/alu_bcond.sv
module alu_bcond #(
    parameter int W = 8
) (
    input  logic [W-1:0] b,
    input  logic         s1,
    input  logic         s0,
    output logic [W-1:0] y
);
    // One small gate term per bit in place of a W-bit 4-to-1 multiplexer
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = (b[i] & s0) | (~b[i] & s1);
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         ov
);
    logic [W:0] cy;

    assign cy[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic p;
        assign p       = x[i] ^ y[i];
        assign sum[i]  = p ^ cy[i];
        assign cy[i+1] = (x[i] & y[i]) | (p & cy[i]);
    end

    assign co = cy[W];
    // Signed overflow: the carry into the sign bit differs from the carry out of it
    assign ov = cy[W] ^ cy[W-1];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  alu_pkg::logic_fn_e fn,
    output logic [W-1:0]       r
);
    import alu_pkg::*;

    always_comb begin
        unique case (fn)
            LF_AND:  r = a & b;
            LF_OR:   r = a | b;
            LF_XOR:  r = a ^ b;
            default: r = ~a;
        endcase
    end
endmodule

// File: rtl/alu_outsel.sv
module alu_outsel #(
    parameter int W = 8
) (
    input  logic [W-1:0]         arith_r,
    input  logic [W-1:0]         logic_r,
    input  logic                 use_logic,
    input  logic                 add_c,
    input  logic                 add_v,
    output logic [W-1:0]         r,
    output alu_pkg::alu_flags_t  f
);
    localparam int MSB = W - 1;

    always_comb begin
        if (use_logic) begin
            r   = logic_r;
            f.c = 1'b0;
            f.v = 1'b0;
        end else begin
            r   = arith_r;
            f.c = add_c;
            f.v = add_v;
        end
        f.z = ~|r;
        f.n = r[MSB];
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [2:0]   sel,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf,
    output logic         zero,
    output logic         neg
);
    import alu_pkg::*;

    alu_sel_t   sd;
    alu_flags_t fl;
    logic [W-1:0] ycond;
    logic [W-1:0] sum_w;
    logic [W-1:0] lres_w;
    logic         add_co;
    logic         add_ov;

    assign sd = decode_sel(sel);

    alu_bcond #(.W(W)) u_bcond (
        .b  (opb),
        .s1 (sd.fn[1]),
        .s0 (sd.fn[0]),
        .y  (ycond)
    );

    alu_adder #(.W(W)) u_adder (
        .x   (opa),
        .y   (ycond),
        .ci  (cin),
        .sum (sum_w),
        .co  (add_co),
        .ov  (add_ov)
    );

    alu_logic #(.W(W)) u_logic (
        .a  (opa),
        .b  (opb),
        .fn (logic_fn_e'(sd.fn)),
        .r  (lres_w)
    );

    alu_outsel #(.W(W)) u_outsel (
        .arith_r   (sum_w),
        .logic_r   (lres_w),
        .use_logic (sd.use_logic),
        .add_c     (add_co),
        .add_v     (add_ov),
        .r         (res),
        .f         (fl)
    );

    assign cout = fl.c;
    assign ovf  = fl.v;
    assign zero = fl.z;
    assign neg  = fl.n;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [2:0]   sel,
    input logic         cin,
    input logic [W-1:0] res,
    input logic         cout,
    input logic         ovf,
    input logic         zero,
    input logic         neg
);
    localparam int MSB = W - 1;

    logic [W-1:0] ref_y;
    logic [W:0]   ref_sum;
    logic [W-1:0] ref_log;

    always_comb begin
        case (sel[1:0])
            2'b00:   ref_y = '0;
            2'b01:   ref_y = opb;
            2'b10:   ref_y = ~opb;
            default: ref_y = '1;
        endcase
        ref_sum = {1'b0, opa} + {1'b0, ref_y} + {{W{1'b0}}, cin};
        case (sel[1:0])
            2'b00:   ref_log = opa & opb;
            2'b01:   ref_log = opa | opb;
            2'b10:   ref_log = opa ^ opb;
            default: ref_log = ~opa;
        endcase
    end

    always_comb begin
        if (!$isunknown({opa, opb, sel, cin, res, cout, ovf, zero, neg})) begin
            // R1
            arith_sum_chk: assert (sel[2] || ({cout, res} == ref_sum))
                else $error("arith_sum_chk: sum mismatch");
            // R6
            logic_fn_chk: assert (!sel[2] || (res == ref_log))
                else $error("logic_fn_chk: logic result mismatch");
            // R8
            logic_flags_clear_chk: assert (!sel[2] || (!cout && !ovf))
                else $error("logic_flags_clear_chk: carry or overflow set in logic mode");
            // R5
            ovf_sign_chk: assert (sel[2] || !ovf || (res[MSB] != opa[MSB]))
                else $error("ovf_sign_chk: overflow without sign change");
            // R9
            zero_result_chk: assert (!zero || (!neg && (res == '0)))
                else $error("zero_result_chk: zero flag with nonzero result");
        end
    end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
    .opa  (opa),
    .opb  (opb),
    .sel  (sel),
    .cin  (cin),
    .res  (res),
    .cout (cout),
    .ovf  (ovf),
    .zero (zero),
    .neg  (neg)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int W     = 8;
    localparam int MSB   = W - 1;
    localparam int NPAT  = 6;
    localparam int NRAND = 64;

    typedef struct {
        logic [W-1:0] g;
        logic         c;
        logic         v;
        logic         z;
        logic         n;
        string        tg;
        string        tc;
        string        tv;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [2:0]   sel = '0;
    logic         cin = 1'b0;
    logic [W-1:0] res;
    logic         cout, ovf, zero, neg;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sbq[$];

    always #5 clk = ~clk;

    alu_core #(.W(W)) dut (
        .opa (opa), .opb (opb), .sel (sel), .cin (cin),
        .res (res), .cout (cout), .ovf (ovf), .zero (zero), .neg (neg)
    );

    function automatic logic [W-1:0] pattern(input int k);
        logic [W-1:0] p;
        case (k)
            0:       p = '0;
            1:       p = '1;
            2:       p = {1'b1, {(W-1){1'b0}}};
            3:       p = {1'b0, {(W-1){1'b1}}};
            4:       p = {{(W-1){1'b0}}, 1'b1};
            default: p = {(W/2){2'b01}};
        endcase
        return p;
    endfunction

    // Reference model taken from R1..R10
    function automatic exp_t ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [2:0] s, input logic ci);
        exp_t e;
        logic [W-1:0] y;
        logic [W:0]   t;
        if (!s[2]) begin
            case (s[1:0])
                2'b00:   y = '0;
                2'b01:   y = b;
                2'b10:   y = ~b;
                default: y = '1;
            endcase
            t   = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, ci};
            e.g = t[MSB:0];
            e.c = t[W];
            e.v = (a[MSB] == y[MSB]) && (e.g[MSB] != a[MSB]);
            e.tg = "R1 R2"; e.tc = "R4"; e.tv = "R5";
        end else begin
            case (s[1:0])
                2'b00:   e.g = a & b;
                2'b01:   e.g = a | b;
                2'b10:   e.g = a ^ b;
                default: e.g = ~a;
            endcase
            e.c = 1'b0;
            e.v = 1'b0;
            e.tg = "R6 R7"; e.tc = "R8"; e.tv = "R8";
        end
        e.z = (e.g == '0);
        e.n = e.g[MSB];
        return e;
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2:0] s, input logic ci, input exp_t e);
        @(posedge clk);
        #1;
        opa = a; opb = b; sel = s; cin = ci;
        sbq.push_back(e);
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2:0] s, input logic ci);
        apply(a, b, s, ci, ref_model(a, b, s, ci));
    endtask

    // R3: subtraction checked against plain a - b
    task automatic drive_sub(input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t e;
        e.g = a - b;
        e.c = (a >= b);
        e.v = (a[MSB] != b[MSB]) && (e.g[MSB] != a[MSB]);
        e.z = (e.g == '0);
        e.n = e.g[MSB];
        e.tg = "R3"; e.tc = "R3"; e.tv = "R3";
        apply(a, b, 3'b010, 1'b1, e);
    endtask

    // R3: decrement checked against plain a - 1
    task automatic drive_dec(input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t e;
        e.g = a - 1'b1;
        e.c = (a != '0);
        e.v = a[MSB] && !e.g[MSB];
        e.z = (e.g == '0);
        e.n = e.g[MSB];
        e.tg = "R3"; e.tc = "R3"; e.tv = "R3";
        apply(a, b, 3'b011, 1'b0, e);
    endtask

    task automatic cmp1(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b (a=%h b=%h sel=%b cin=%b)",
                     tag, nm, act, exp, opa, opb, sel, cin);
        end
    endtask

    // Monitor: pops one expected item per cycle at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if (res !== e.g) begin
                    errors++;
                    $display("FAIL %s res: actual=%h expected=%h (a=%h b=%h sel=%b cin=%b)",
                             e.tg, res, e.g, opa, opb, sel, cin);
                end
                cmp1(e.tc, "cout", cout, e.c);
                cmp1(e.tv, "ovf", ovf, e.v);
                cmp1("R9", "zero", zero, e.z);
                cmp1("R10", "neg", neg, e.n);
            end
        end
    end

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=expired expected=run complete");
            report();
        end
    end

    initial begin
        logic [W-1:0] ra, rb;
        ra = 8'h5a;
        rb = 8'hc3;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset state: zero inputs give a zero result with zero flag set (R9)
        drive('0, '0, 3'b000, 1'b0);

        // Sweep all select/carry codes over corner operands (R1 R2 R4 R5 R6 R7 R8)
        for (int s = 0; s < 8; s++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int i = 0; i < NPAT; i++) begin
                    for (int j = 0; j < NPAT; j++) begin
                        drive(pattern(i), pattern(j), 3'(s), 1'(ci));
                    end
                end
            end
        end

        // Pseudo-random operands over every code
        for (int k = 0; k < NRAND; k++) begin
            ra = {ra[W-2:0], ra[MSB] ^ ra[W-3]} ^ 8'(k);
            rb = rb ^ {rb[W-4:0], 3'b101} ^ 8'(k * 7);
            drive(ra, rb, 3'(k % 8), 1'(k / 8));
            drive(ra, rb, 3'(k % 8), !1'(k / 8));
        end

        // R3: subtraction and decrement against plain arithmetic
        for (int i = 0; i < NPAT; i++) begin
            for (int j = 0; j < NPAT; j++) begin
                drive_sub(pattern(i), pattern(j));
            end
            drive_dec(pattern(i), pattern(i));
        end
        drive_sub(8'h37, 8'h92);
        drive_dec(8'h80, 8'h11);

        repeat (3) @(posedge clk);
        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard: actual=%0d pending expected=0", sbq.size());
        end
        done = 1'b1;
        report();
    end
endmodule